// File: doc/BRIEF.md
# SDRAM single-access command sequencer

This block performs one 16-bit SDRAM access at a time. A requester offers bank, row, column, direction and (for a write) a data word over a ready/valid handshake. The block then drives the memory command pins, bank, address and data bus one clock cycle at a time. It opens the row, issues the column command, waits out the programmed delays and closes every bank with a single precharge-all. For a read it captures the returned word and presents it with a one-cycle valid strobe.

All delays come from five small timing fields that are held static while accesses run. The row-to-column, row-active, precharge and write-recovery fields are stored as the cycle count minus one. The CAS-latency field holds the cycle count itself. The block also checks the programmed settings. If they are inconsistent, it raises a configuration-error flag and refuses new work until they are corrected.

Top module: `sdram_single_seq`

## Requirements
- R1: After reset, sdCmd shows deselect, sdDqOe and rdValid are low, and reqReady is high when the timing fields are legal.
- R2: sdCmd is {cs_n, ras_n, cas_n, we_n}, with these encodings: activate 4'b0011, read 4'b0101, write 4'b0100, precharge 4'b0010, deselect 4'b1111. Every cycle that carries no command shows deselect.
- R3: A request is accepted at a rising edge where reqValid and reqReady are both high. The activate command appears right after that edge (cycle 0), with sdBank equal to the request bank and sdAddr equal to the row.
- R4: The read or write command appears in cycle tRcd = cfgRowCol+1 (2-bit field). sdAddr then holds the column, zero-extended, so bit 10 (auto-precharge) is 0, and sdBank is unchanged.
- R5: For a write, sdDqOe is high only during the write-command cycle, and sdDqOut carries the request data in that cycle.
- R6: For a read, rdData takes the value on sdDqIn at rising edge tRcd+CL, with CL = cfgCasLat taken directly (3 bits). rdValid is high for exactly the following cycle.
- R7: The precharge-all command appears with sdAddr bit 10 = 1 in cycle P. For a read, P = max(tRas, tRcd+CL-1). For a write, P = max(tRas, tRcd+tWr). Here tRas = cfgRowAct+1 (3 bits) and tWr = cfgWrRec+1 (1 bit). Precharge therefore never precedes the row-active period.
- R8: reqReady rises in cycle P+tRp, with tRp = cfgPrechg+1 (3 bits). A waiting request then produces its activate P+tRp+1 cycles after the previous activate, so at least tRp cycles after the precharge.
- R9: cfgError is high exactly when cfgCasLat is neither 2 nor 3, or when tRas > tRcd+CL.
- R10: While cfgError is high, reqReady is low and no command other than deselect starts, whatever reqValid does.
- R11: reqReady is low from the accepting edge until cycle P+tRp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the memory clock is in phase with it |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Sequencer idle and configuration legal |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBank | input | BANK_W | Bank of the access |
| reqRow | input | ROW_W | Row address |
| reqCol | input | COL_W | Column address |
| reqWdata | input | DATA_W | Write data |
| cfgCasLat | input | 3 | CAS latency in cycles |
| cfgRowCol | input | 2 | Row-to-column delay minus one |
| cfgRowAct | input | 3 | Row-active period minus one |
| cfgPrechg | input | 3 | Precharge period minus one |
| cfgWrRec | input | 1 | Write-recovery period minus one |
| cfgError | output | 1 | Timing fields inconsistent |
| sdCmd | output | 4 | {cs_n, ras_n, cas_n, we_n} |
| sdBank | output | BANK_W | Memory bank address |
| sdAddr | output | ROW_W | Memory address bus |
| sdDqOut | output | DATA_W | Data driven to memory |
| sdDqOe | output | 1 | Data bus output enable |
| sdDqIn | input | DATA_W | Data from memory |
| rdData | output | DATA_W | Captured read word |
| rdValid | output | 1 | rdData valid for one cycle |

## Verification
The bench runs several timing settings and computes where each command should fall. It covers one setting where the row-active period sets the precharge and others where the column delay plus CAS latency or write recovery sets it. A design that ignored the offset encoding, or took the wrong maximum, would put the column command or precharge one cycle early or late. The read-data word is placed on the bus only in the single cycle before the correct capture edge, so a latency counted from the wrong edge returns the inverted pattern. Back-to-back requests measure the activate spacing exactly, which catches a precharge-period gap that is too short or one cycle too long. Illegal CAS codes, and a row-active period just over or exactly at its limit, must raise the error flag and block all commands, or not.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

  typedef logic [3:0] sdCmd_t;

  // {cs_n, ras_n, cas_n, we_n}
  localparam sdCmd_t CMD_ACT = 4'b0011;
  localparam sdCmd_t CMD_RD  = 4'b0101;
  localparam sdCmd_t CMD_WR  = 4'b0100;
  localparam sdCmd_t CMD_PRE = 4'b0010;
  localparam sdCmd_t CMD_DSL = 4'b1111;

  localparam int CL_W  = 3;
  localparam int RCD_W = 2;
  localparam int RAS_W = 3;
  localparam int RP_W  = 3;

  typedef struct packed {
    logic issueAct;
    logic issueRw;
    logic issuePre;
    logic rwIsWrite;
    logic capture;
  } seqStrobe_t;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_BUSY = 1'b1
  } seqState_t;

endpackage

// File: rtl/sdseq_ctrl.sv
module sdseq_ctrl
  import sdseq_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  output logic             reqReady,
  input  logic [CL_W-1:0]  cfgCasLat,
  input  logic [RCD_W-1:0] cfgRowCol,
  input  logic [RAS_W-1:0] cfgRowAct,
  input  logic [RP_W-1:0]  cfgPrechg,
  input  logic             cfgWrRec,
  output logic             cfgError,
  output seqStrobe_t       strobe
);

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] nextCnt;
  logic             busyWrite;
  logic             accept;

  logic [CNT_W-1:0] tRcd, tRas, tRp, tWr, casLat;
  logic [CNT_W-1:0] rdPre, wrPre, preAt, dataAt, endAt;

  // Decoded delays: offset fields add one, CAS latency is direct
  always_comb begin
    tRcd   = CNT_W'(cfgRowCol) + CNT_W'(1);
    tRas   = CNT_W'(cfgRowAct) + CNT_W'(1);
    tRp    = CNT_W'(cfgPrechg) + CNT_W'(1);
    tWr    = CNT_W'(cfgWrRec)  + CNT_W'(1);
    casLat = CNT_W'(cfgCasLat);
    rdPre  = tRcd + casLat - CNT_W'(1);
    wrPre  = tRcd + tWr;
    if (busyWrite) preAt = (tRas > wrPre) ? tRas : wrPre;
    else           preAt = (tRas > rdPre) ? tRas : rdPre;
    dataAt = tRcd + casLat;
    endAt  = preAt + tRp;
  end

  always_comb begin
    cfgError = ((cfgCasLat != 3'd2) && (cfgCasLat != 3'd3)) ||
               (tRas > (tRcd + casLat));
  end

  assign reqReady = (state == S_IDLE) && !cfgError;
  assign accept   = reqValid && reqReady;
  assign nextCnt  = cnt + CNT_W'(1);

  always_comb begin
    strobe           = '0;
    strobe.issueAct  = accept;
    strobe.rwIsWrite = busyWrite;
    if (state == S_BUSY) begin
      strobe.issueRw  = (nextCnt == tRcd);
      strobe.issuePre = (nextCnt == preAt);
      strobe.capture  = !busyWrite && (nextCnt == dataAt);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      cnt       <= '0;
      busyWrite <= 1'b0;
    end else if (accept) begin
      state     <= S_BUSY;
      cnt       <= '0;
      busyWrite <= reqWrite;
    end else if (state == S_BUSY) begin
      cnt <= nextCnt;
      if (nextCnt == endAt) state <= S_IDLE;
    end
  end

  // Cycles since the precharge reached the pins (saturating)
  logic [CNT_W-1:0] preAge;
  always_ff @(posedge clk) begin
    if (!rstN)                preAge <= '1;
    else if (strobe.issuePre) preAge <= CNT_W'(1);
    else if (preAge != '1)    preAge <= preAge + CNT_W'(1);
  end

  assert_single_cmd_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.issueAct, strobe.issueRw, strobe.issuePre}));

  assert_row_active_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issuePre |-> (nextCnt >= tRas));

  assert_prechg_gap_R8: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> (preAge >= tRp));

  assert_busy_blocks_R11: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !reqReady);

endmodule

// File: rtl/sdseq_datapath.sv
module sdseq_datapath
  import sdseq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  parameter int DATA_W = 16,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] sdDqIn,
  output sdCmd_t            sdCmd,
  output logic [BANK_W-1:0] sdBank,
  output logic [ROW_W-1:0]  sdAddr,
  output logic [DATA_W-1:0] sdDqOut,
  output logic              sdDqOe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  localparam logic [ROW_W-1:0] PRE_ALL_ADDR = ROW_W'(1) << AP_BIT;

  logic [COL_W-1:0]  colQ;
  logic [DATA_W-1:0] wdataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colQ   <= '0;
      wdataQ <= '0;
    end else if (strobe.issueAct) begin
      colQ   <= reqCol;
      wdataQ <= reqWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdCmd   <= CMD_DSL;
      sdBank  <= '0;
      sdAddr  <= '0;
      sdDqOut <= '0;
      sdDqOe  <= 1'b0;
    end else begin
      sdCmd  <= CMD_DSL;
      sdDqOe <= 1'b0;
      if (strobe.issueAct) begin
        sdCmd  <= CMD_ACT;
        sdBank <= reqBank;
        sdAddr <= reqRow;
      end else if (strobe.issueRw) begin
        sdCmd  <= strobe.rwIsWrite ? CMD_WR : CMD_RD;
        sdAddr <= ROW_W'(colQ);
        if (strobe.rwIsWrite) begin
          sdDqOut <= wdataQ;
          sdDqOe  <= 1'b1;
        end
      end else if (strobe.issuePre) begin
        sdCmd  <= CMD_PRE;
        sdAddr <= PRE_ALL_ADDR;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.capture;
      if (strobe.capture) rdData <= sdDqIn;
    end
  end

  assert_dq_on_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    sdDqOe |-> (sdCmd == CMD_WR));

  assert_rd_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

endmodule

// File: rtl/sdram_single_seq.sv
module sdram_single_seq
  import sdseq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  parameter int DATA_W = 16,
  parameter int AP_BIT = 10,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [2:0]        cfgCasLat,
  input  logic [1:0]        cfgRowCol,
  input  logic [2:0]        cfgRowAct,
  input  logic [2:0]        cfgPrechg,
  input  logic              cfgWrRec,
  output logic              cfgError,
  output logic [3:0]        sdCmd,
  output logic [BANK_W-1:0] sdBank,
  output logic [ROW_W-1:0]  sdAddr,
  output logic [DATA_W-1:0] sdDqOut,
  output logic              sdDqOe,
  input  logic [DATA_W-1:0] sdDqIn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  seqStrobe_t strobe;

  sdseq_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqReady  (reqReady),
    .cfgCasLat (cfgCasLat),
    .cfgRowCol (cfgRowCol),
    .cfgRowAct (cfgRowAct),
    .cfgPrechg (cfgPrechg),
    .cfgWrRec  (cfgWrRec),
    .cfgError  (cfgError),
    .strobe    (strobe)
  );

  sdseq_datapath #(
    .BANK_W (BANK_W),
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .DATA_W (DATA_W),
    .AP_BIT (AP_BIT)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqBank  (reqBank),
    .reqRow   (reqRow),
    .reqCol   (reqCol),
    .reqWdata (reqWdata),
    .sdDqIn   (sdDqIn),
    .sdCmd    (sdCmd),
    .sdBank   (sdBank),
    .sdAddr   (sdAddr),
    .sdDqOut  (sdDqOut),
    .sdDqOe   (sdDqOe),
    .rdData   (rdData),
    .rdValid  (rdValid)
  );

  assert_no_act_on_error_R10: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |=> (sdCmd != CMD_ACT));

endmodule

// File: tb/tb_sdram_single_seq.sv
module tb_sdram_single_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqBank = '0;
  logic [12:0] reqRow = '0;
  logic [8:0]  reqCol = '0;
  logic [15:0] reqWdata = '0;
  logic [2:0]  cfgCasLat = 3'd3;
  logic [1:0]  cfgRowCol = 2'd0;
  logic [2:0]  cfgRowAct = 3'd2;
  logic [2:0]  cfgPrechg = 3'd0;
  logic        cfgWrRec = 1'b1;
  logic        cfgError;
  logic [3:0]  sdCmd;
  logic [1:0]  sdBank;
  logic [12:0] sdAddr;
  logic [15:0] sdDqOut;
  logic        sdDqOe;
  logic [15:0] sdDqIn = '0;
  logic [15:0] rdData;
  logic        rdValid;

  always #2.5 clk = ~clk;

  sdram_single_seq dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol),
    .reqWdata(reqWdata), .cfgCasLat(cfgCasLat), .cfgRowCol(cfgRowCol),
    .cfgRowAct(cfgRowAct), .cfgPrechg(cfgPrechg), .cfgWrRec(cfgWrRec),
    .cfgError(cfgError), .sdCmd(sdCmd), .sdBank(sdBank), .sdAddr(sdAddr),
    .sdDqOut(sdDqOut), .sdDqOe(sdDqOe), .sdDqIn(sdDqIn), .rdData(rdData),
    .rdValid(rdValid)
  );

  localparam logic [3:0] ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100,
                         PRE = 4'b0010, DSL = 4'b1111;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  int prevAct = 0;
  int prevEnd = 0;
  bit done    = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finishRun();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  // One access; called just after a negedge while idle
  task automatic runAccess(input bit wr, input logic [1:0] bank, input logic [12:0] row,
                           input logic [8:0] col, input logic [15:0] data, input bit chkGap);
    int tRcd, tRas, tRp, tWr, cl, p, d, e, actCyc;
    logic [3:0] expCmd;
    tRcd = int'(cfgRowCol) + 1;
    tRas = int'(cfgRowAct) + 1;
    tRp  = int'(cfgPrechg) + 1;
    tWr  = int'(cfgWrRec) + 1;
    cl   = int'(cfgCasLat);
    if (wr) p = (tRas > tRcd + tWr) ? tRas : tRcd + tWr;
    else    p = (tRas > tRcd + cl - 1) ? tRas : tRcd + cl - 1;
    d = tRcd + cl;
    e = p + tRp;
    chk("R11 ready before request", {31'd0, reqReady}, 32'd1);
    reqValid = 1'b1; reqWrite = wr; reqBank = bank; reqRow = row;
    reqCol = col; reqWdata = data;
    @(posedge clk);
    @(negedge clk);
    actCyc = cyc;
    reqValid = 1'b0;
    reqWdata = ~data;
    if (chkGap) chk("R8 activate spacing", actCyc - prevAct, prevEnd + 1);
    for (int k = 0; k <= e; k++) begin
      if (k > 0) @(negedge clk);
      sdDqIn = (!wr && k == d - 1) ? data : ~data;
      if (k == 0) expCmd = ACT;
      else if (k == tRcd) expCmd = wr ? WR : RD;
      else if (k == p) expCmd = PRE;
      else expCmd = DSL;
      chk("R2 command pins", {28'd0, sdCmd}, {28'd0, expCmd});
      if (k == 0) begin
        chk("R3 activate bank", {30'd0, sdBank}, {30'd0, bank});
        chk("R3 activate row", {19'd0, sdAddr}, {19'd0, row});
      end
      if (k == tRcd) begin
        chk("R4 column address", {19'd0, sdAddr}, {23'd0, col});
        chk("R4 column bank", {30'd0, sdBank}, {30'd0, bank});
      end
      if (k == p) chk("R7 precharge-all bit", {31'd0, sdAddr[10]}, 32'd1);
      chk("R5 output enable", {31'd0, sdDqOe}, {31'd0, (wr && k == tRcd)});
      if (wr && k == tRcd) chk("R5 write data", {16'd0, sdDqOut}, {16'd0, data});
      chk("R6 read valid", {31'd0, rdValid}, {31'd0, (!wr && k == d)});
      if (!wr && k == d) chk("R6 read data", {16'd0, rdData}, {16'd0, data});
      chk("R11 ready while busy", {31'd0, reqReady}, {31'd0, (k == e)});
    end
    prevAct = actCyc;
    prevEnd = e;
  endtask

  task automatic setCfg(input logic [2:0] cl, input logic [1:0] rcd, input logic [2:0] ras,
                        input logic [2:0] rp, input logic wrr);
    cfgCasLat = cl; cfgRowCol = rcd; cfgRowAct = ras; cfgPrechg = rp; cfgWrRec = wrr;
    @(negedge clk);
  endtask

  // R9/R10: illegal settings must flag and block
  task automatic errCase(input logic [2:0] cl, input logic [1:0] rcd, input logic [2:0] ras,
                         input bit expErr);
    setCfg(cl, rcd, ras, 3'd0, 1'b0);
    chk("R9 config error flag", {31'd0, cfgError}, {31'd0, expErr});
    chk("R10 ready vs error", {31'd0, reqReady}, {31'd0, !expErr});
    if (expErr) begin
      reqValid = 1'b1; reqWrite = 1'b0;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        chk("R10 no command on error", {28'd0, sdCmd}, {28'd0, DSL});
      end
      reqValid = 1'b0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset command", {28'd0, sdCmd}, {28'd0, DSL});
    chk("R1 reset oe", {31'd0, sdDqOe}, 32'd0);
    chk("R1 reset valid", {31'd0, rdValid}, 32'd0);
    chk("R1 reset ready", {31'd0, reqReady}, 32'd1);
    chk("R1 reset error", {31'd0, cfgError}, 32'd0);

    // CL3, tRcd1, tRas3, tRp1, tWr2
    setCfg(3'd3, 2'd0, 3'd2, 3'd0, 1'b1);
    runAccess(1'b0, 2'd1, 13'h1abc, 9'h055, 16'hbeef, 1'b0);
    runAccess(1'b1, 2'd2, 13'h0123, 9'h1ff, 16'h1234, 1'b1);
    runAccess(1'b0, 2'd3, 13'h1fff, 9'h000, 16'ha5a5, 1'b1);

    // CL2, tRcd2, tRas4 dominant, tRp3, tWr1
    setCfg(3'd2, 2'd1, 3'd3, 3'd2, 1'b0);
    runAccess(1'b0, 2'd0, 13'h0042, 9'h101, 16'h5a5a, 1'b0);
    runAccess(1'b1, 2'd1, 13'h0f0f, 9'h0aa, 16'hc3c3, 1'b1);

    // CL3, tRcd4, tRas1, tRp1, tWr2
    setCfg(3'd3, 2'd3, 3'd0, 3'd0, 1'b1);
    runAccess(1'b1, 2'd2, 13'h1555, 9'h155, 16'h0f0f, 1'b0);
    runAccess(1'b0, 2'd0, 13'h0aaa, 9'h0ff, 16'hf00d, 1'b1);

    // Boundary: tRas == tRcd + CL is legal
    errCase(3'd2, 2'd0, 3'd2, 1'b0);
    runAccess(1'b0, 2'd1, 13'h0777, 9'h011, 16'h7e7e, 1'b0);

    errCase(3'd1, 2'd0, 3'd0, 1'b1);
    errCase(3'd4, 2'd0, 3'd0, 1'b1);
    errCase(3'd0, 2'd1, 3'd0, 1'b1);
    errCase(3'd2, 2'd0, 3'd3, 1'b1);

    // Recovery after a legal setting is restored
    setCfg(3'd3, 2'd0, 3'd2, 3'd0, 1'b1);
    chk("R9 error cleared", {31'd0, cfgError}, 32'd0);
    runAccess(1'b1, 2'd3, 13'h0001, 9'h001, 16'h8001, 1'b0);

    finishRun();
  end

endmodule